// File: doc/BRIEF.md
# Pipelined Crate Command Frame Executor

This block executes a queue of self-describing 64-bit command frames on a CAMAC-style crate dataway. Each frame is taken from an upstream FIFO over a valid/ready stream and names a station, a sub-address and a function. The block runs one dataway cycle for that frame. It raises Busy, drives the address and function lines, strobes S1 and then S2, and samples the module's Q, X and read-data responses on the last S1 tick. It then offers a 64-bit reply frame on an output valid/ready stream. If another frame is waiting when the reply is taken, the next cycle starts on the following clock and Busy stays high between the frames.

The command frame can ask for a fast cycle, which leaves out the S2 strobe. Frames addressed to the controller's own station number do not access a module. Instead they pulse crate-wide clear (C) or initialize (Z) during the S2 window. An online input gates whether new frames may start. Sticky-free status pins report whether the most recent cycle lacked Q or lacked X. A one-clock packet-done pulse follows the reply of a frame marked as the last of its packet.

Back-pressure: a frame is consumed only on a clock where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while online, and only when the block is idle or is handing over its reply in that same clock. A reply is presented with `rsp_valid` and stays unchanged until `rsp_ready` is seen. While the reply waits, no new frame is started, so no reply is ever dropped.

Top module: `crate_frame_exec`

## Requirements
- R1: Command frame layout is: [63:56] header tag, [55:51] station N, [50:47] sub-address A, [46:42] function F, [41] last-of-packet, [40] fast, [39:24] tag, [23:0] write data. While Busy is high, `bus_n`/`bus_a`/`bus_f` carry the frame's fields, and they are zero while idle. `bus_wdata` carries the data field only for write functions (F 16..23) on a non-controller station, and is zero otherwise.
- R2: A normal cycle is T_SETUP ticks of Busy alone, then T_S1 ticks of S1, then T_S2 ticks of S2, then T_REL ticks of release, and then the reply is offered. With defaults 50/50/80/79 at 250 MHz, a frame whose reply is taken at once occupies 260 clocks (1.04 µs).
- R3: A frame with bit 40 set on a non-controller station skips the S2 window entirely. With defaults this gives 180 clocks (0.72 µs).
- R4: Reply frame layout is: [63:56] header tag echoed, [55:42] N/A/F echoed, [41] Q, [40] X, [39:24] tag echoed, [23:0] read data. Q, X and read data are sampled on the last S1 tick.
- R5: Reply read data is the sampled `bus_rdata` only for read functions (F 0..7) on a non-controller station. Otherwise it is zero.
- R6: Station CTRL_STN (default 30) is the controller itself. S1 is not driven, the fast bit is ignored, S2 runs, and `bus_c` (A=0) or `bus_z` (A=1) is high throughout the S2 window. The reply carries Q=X=1 for A=0 or A=1, and Q=X=0 with no pulse for any other A.
- R7: `noq_flag` and `nox_flag` show the inverted Q and X of the most recently sampled cycle, updated at the sample tick. Both are 0 after reset.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the reply is held stable, Busy stays high and no new frame starts.
- R9: When a reply is taken in the same clock that a new frame is accepted, the next setup phase starts on the following clock and Busy does not drop.
- R10: While `online` is low, `cmd_ready` is low and no frame starts. A frame already in progress still completes and delivers its reply.
- R11: `pkt_done` is a single-clock pulse in the clock after the reply of a frame with bit 41 set has been taken.
- R12: After reset, Busy, strobes, C, Z, `rsp_valid`, `pkt_done`, both flags and all bus address lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online | input | 1 | Crate access enable |
| cmd_valid | input | 1 | Command frame valid |
| cmd_ready | output | 1 | Command frame accepted this clock when valid |
| cmd_frame | input | 64 | Command frame |
| rsp_valid | output | 1 | Reply frame valid |
| rsp_ready | input | 1 | Downstream can take reply |
| rsp_frame | output | 64 | Reply frame |
| bus_busy | output | 1 | Dataway Busy |
| bus_n | output | 5 | Station number |
| bus_a | output | 4 | Sub-address |
| bus_f | output | 5 | Function code |
| bus_wdata | output | 24 | Write data lines |
| bus_s1 | output | 1 | First strobe |
| bus_s2 | output | 1 | Second strobe |
| bus_c | output | 1 | Crate clear |
| bus_z | output | 1 | Crate initialize |
| bus_q | input | 1 | Module Q response |
| bus_x | input | 1 | Module X response |
| bus_rdata | input | 24 | Read data lines |
| noq_flag | output | 1 | Last cycle had no Q |
| nox_flag | output | 1 | Last cycle had no X |
| pkt_done | output | 1 | Packet finished pulse |

## Verification
The assertions take for granted that every phase length is at least one tick. They also assume that the crate responder has settled Q, X and read data by the final S1 tick; they place no rule on how `cmd_valid` or `rsp_ready` behave, since only handshakes matter. The bench's responder changes its lines only at the falling clock edge, as a function of the station being driven. Its downstream drops `rsp_ready` for several clocks at a time inside bursts, and it drops `online` both mid-frame and while frames are queued, so the hold and gating properties are exercised under legal but hostile input patterns.

// File: rtl/crate_exec_pkg.sv
package crate_exec_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_S1, PH_S2, PH_REL, PH_RSP
  } phase_t;

  // command frame view
  typedef struct packed {
    logic [7:0]  tag_hi;
    logic [4:0]  n;
    logic [3:0]  a;
    logic [4:0]  f;
    logic        last;
    logic        fast;
    logic [15:0] tag_lo;
    logic [23:0] data;
  } cmd_t;

  localparam int DATA_W = 24;

endpackage

// File: rtl/crate_frame_decode.sv
module crate_frame_decode
  import crate_exec_pkg::*;
#(
  parameter int CTRL_STN = 30
) (
  input  logic [4:0] n,
  input  logic [3:0] a,
  input  logic [4:0] f,
  input  logic       fast,
  output logic       special,
  output logic       is_rd,
  output logic       is_wr,
  output logic       c_sel,
  output logic       z_sel,
  output logic       skip_s2
);
  always_comb begin
    special = (n == 5'(CTRL_STN));
    is_rd   = !special && (f[4:3] == 2'b00);
    is_wr   = !special && (f[4:3] == 2'b10);
    c_sel   = special && (a == 4'd0);
    z_sel   = special && (a == 4'd1);
    skip_s2 = fast && !special;
  end
endmodule

// File: rtl/crate_cycle_seq.sv
module crate_cycle_seq
  import crate_exec_pkg::*;
#(
  parameter int T_SETUP = 50,
  parameter int T_S1    = 50,
  parameter int T_S2    = 80,
  parameter int T_REL   = 79
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   skip_s2,
  input  logic   rsp_ready,
  output phase_t phase,
  output logic   sample
);
  localparam int T_A   = (T_SETUP > T_S1) ? T_SETUP : T_S1;
  localparam int T_B   = (T_S2 > T_REL) ? T_S2 : T_REL;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt;
  wire last_tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= CNT_W'(T_SETUP - 1);
        end
        PH_SETUP: if (last_tick) begin
          phase <= PH_S1;
          cnt   <= CNT_W'(T_S1 - 1);
        end else cnt <= cnt - 1'b1;
        PH_S1: if (last_tick) begin
          phase <= skip_s2 ? PH_REL : PH_S2;
          cnt   <= skip_s2 ? CNT_W'(T_REL - 1) : CNT_W'(T_S2 - 1);
        end else cnt <= cnt - 1'b1;
        PH_S2: if (last_tick) begin
          phase <= PH_REL;
          cnt   <= CNT_W'(T_REL - 1);
        end else cnt <= cnt - 1'b1;
        PH_REL: if (last_tick) phase <= PH_RSP;
                else cnt <= cnt - 1'b1;
        PH_RSP: if (rsp_ready) begin
          phase <= start ? PH_SETUP : PH_IDLE;
          cnt   <= CNT_W'(T_SETUP - 1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sample = (phase == PH_S1) && last_tick;

  // R3: a fast frame leaves S1 straight for release
  a_r3_fast_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && skip_s2) |=> (phase == PH_REL));
  // R2: S2 is only ever entered from S1
  a_r2_s2_after_s1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_S2) |-> ($past(phase) == PH_S1));
  // R8: a waiting reply keeps the sequencer parked
  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RSP && !rsp_ready) |=> (phase == PH_RSP));
endmodule

// File: rtl/crate_reply_pack.sv
module crate_reply_pack
  import crate_exec_pkg::*;
(
  input  logic [21:0]       echo_hi,
  input  logic [15:0]       echo_lo,
  input  logic              q,
  input  logic              x,
  input  logic              is_rd,
  input  logic [DATA_W-1:0] rdata,
  output logic [63:0]       frame
);
  always_comb
    frame = {echo_hi, q, x, echo_lo, (is_rd ? rdata : {DATA_W{1'b0}})};
endmodule

// File: rtl/crate_frame_exec.sv
module crate_frame_exec
  import crate_exec_pkg::*;
#(
  parameter int CTRL_STN = 30,
  parameter int T_SETUP  = 50,
  parameter int T_S1     = 50,
  parameter int T_S2     = 80,
  parameter int T_REL    = 79
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        online,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [63:0] cmd_frame,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_frame,
  output logic        bus_busy,
  output logic [4:0]  bus_n,
  output logic [3:0]  bus_a,
  output logic [4:0]  bus_f,
  output logic [23:0] bus_wdata,
  output logic        bus_s1,
  output logic        bus_s2,
  output logic        bus_c,
  output logic        bus_z,
  input  logic        bus_q,
  input  logic        bus_x,
  input  logic [23:0] bus_rdata,
  output logic        noq_flag,
  output logic        nox_flag,
  output logic        pkt_done
);
  cmd_t        cur;
  phase_t      phase;
  logic        sample, start;
  logic        special, is_rd, is_wr, c_sel, z_sel, skip_s2;
  logic        q_r, x_r, q_eff, x_eff;
  logic [23:0] rd_r;

  crate_frame_decode #(.CTRL_STN(CTRL_STN)) u_dec (
    .n(cur.n), .a(cur.a), .f(cur.f), .fast(cur.fast),
    .special(special), .is_rd(is_rd), .is_wr(is_wr),
    .c_sel(c_sel), .z_sel(z_sel), .skip_s2(skip_s2)
  );

  crate_cycle_seq #(.T_SETUP(T_SETUP), .T_S1(T_S1), .T_S2(T_S2), .T_REL(T_REL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_s2(skip_s2),
    .rsp_ready(rsp_ready), .phase(phase), .sample(sample)
  );

  crate_reply_pack u_pack (
    .echo_hi({cur.tag_hi, cur.n, cur.a, cur.f}), .echo_lo(cur.tag_lo),
    .q(q_r), .x(x_r), .is_rd(is_rd), .rdata(rd_r), .frame(rsp_frame)
  );

  assign cmd_ready = online && ((phase == PH_IDLE) || (phase == PH_RSP && rsp_ready));
  assign start     = cmd_valid && cmd_ready;
  assign rsp_valid = (phase == PH_RSP);
  assign q_eff     = special ? (c_sel || z_sel) : bus_q;
  assign x_eff     = special ? (c_sel || z_sel) : bus_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      q_r      <= 1'b0;
      x_r      <= 1'b0;
      rd_r     <= '0;
      noq_flag <= 1'b0;
      nox_flag <= 1'b0;
      pkt_done <= 1'b0;
    end else begin
      if (start) cur <= cmd_t'(cmd_frame);
      if (sample) begin
        q_r      <= q_eff;
        x_r      <= x_eff;
        rd_r     <= bus_rdata;
        noq_flag <= !q_eff;
        nox_flag <= !x_eff;
      end
      pkt_done <= rsp_valid && rsp_ready && cur.last;
    end
  end

  always_comb begin
    bus_busy  = (phase != PH_IDLE);
    bus_n     = bus_busy ? cur.n : '0;
    bus_a     = bus_busy ? cur.a : '0;
    bus_f     = bus_busy ? cur.f : '0;
    bus_wdata = (bus_busy && is_wr) ? cur.data : '0;
    bus_s1    = (phase == PH_S1) && !special;
    bus_s2    = (phase == PH_S2);
    bus_c     = bus_s2 && c_sel;
    bus_z     = bus_s2 && z_sel;
  end

  // R8: reply held unchanged under back-pressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame)));
  // R10: no acceptance while offline
  a_r10_offline: assert property (@(posedge clk) disable iff (!rst_n)
    !online |-> !cmd_ready);
  // R6: crate-wide pulses only inside an S2 window without S1
  a_r6_cz_window: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_c || bus_z) |-> (bus_s2 && !bus_s1 && $onehot0({bus_c, bus_z})));
  // R2: strobes never overlap and always sit under Busy
  a_r2_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_s1 || bus_s2) |-> (bus_busy && !(bus_s1 && bus_s2)));
  // R1: address lines quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (bus_n == '0 && bus_f == '0 && bus_wdata == '0));
  // R11: packet-done is a single-clock pulse
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  // R9: Busy stays up across a back-to-back handoff
  a_r9_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && cmd_valid && cmd_ready) |=> bus_busy);
endmodule

// File: tb/tb_crate_frame_exec.sv
`timescale 1ns/1ps
module tb_crate_frame_exec;
  localparam int TS = 50, T1 = 50, T2 = 80, TR = 79, STN = 30;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rst_n = 1'b0, online = 1'b1;
  logic        cmd_valid = 1'b0, rsp_ready = 1'b1;
  logic [63:0] cmd_frame = '0;
  logic        cmd_ready, rsp_valid;
  logic [63:0] rsp_frame;
  logic        bus_busy, bus_s1, bus_s2, bus_c, bus_z;
  logic [4:0]  bus_n, bus_f;
  logic [3:0]  bus_a;
  logic [23:0] bus_wdata, bus_rdata = '0;
  logic        bus_q = 1'b0, bus_x = 1'b0;
  logic        noq_flag, nox_flag, pkt_done;

  crate_frame_exec #(.CTRL_STN(STN), .T_SETUP(TS), .T_S1(T1), .T_S2(T2), .T_REL(TR)) dut (
    .clk(clk), .rst_n(rst_n), .online(online),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_frame(cmd_frame),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .bus_busy(bus_busy), .bus_n(bus_n), .bus_a(bus_a), .bus_f(bus_f),
    .bus_wdata(bus_wdata), .bus_s1(bus_s1), .bus_s2(bus_s2),
    .bus_c(bus_c), .bus_z(bus_z), .bus_q(bus_q), .bus_x(bus_x),
    .bus_rdata(bus_rdata), .noq_flag(noq_flag), .nox_flag(nox_flag),
    .pkt_done(pkt_done)
  );

  int compared = 0, mismatched = 0;
  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk(bit last, bit fast, int n, int a, int f, int tag, int data);
    return {8'(tag + 8'h40), 5'(n), 4'(a), 5'(f), last, fast, 16'(tag * 16'h0101), 24'(data)};
  endfunction
  function automatic bit is_spec(logic [63:0] fr); return fr[55:51] == 5'(STN); endfunction
  function automatic int flen(logic [63:0] fr);
    return TS + T1 + ((fr[40] && !is_spec(fr)) ? 0 : T2) + TR;
  endfunction
  function automatic logic [23:0] resp_data(logic [63:0] fr);
    return {fr[55:42], 10'h2A5};
  endfunction

  // crate responder
  always @(negedge clk) begin
    bus_q     = (bus_n != 5'd7);
    bus_x     = (bus_n != 5'd9);
    bus_rdata = {bus_n, bus_a, bus_f, 10'h2A5};
  end

  // reference model
  logic [63:0] fq[$];
  int          ntook = 0, npop = 0;
  bit          m_act = 0, m_pkt = 0, m_noq = 0, m_nox = 0, m_q = 0, m_x = 0;
  int          m_t = 0;
  logic [63:0] m_cur = '0;
  logic [23:0] m_rd = '0;
  bit          feed_en = 1, stall_mode = 0;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_pkt = 0; m_noq = 0; m_nox = 0;
    end else begin
      m_pkt = 0;
      if (cmd_valid && cmd_ready) ntook++;
      if (!m_act) begin
        if (cmd_valid && online) begin m_cur = cmd_frame; m_act = 1; m_t = 0; end
      end else if (m_t >= flen(m_cur)) begin
        if (rsp_ready) begin
          m_pkt = m_cur[41];
          if (cmd_valid && online) begin m_cur = cmd_frame; m_t = 0; end
          else m_act = 0;
        end
      end else begin
        if (m_t == TS + T1 - 1) begin
          if (is_spec(m_cur)) begin
            m_q = (m_cur[50:47] < 4'd2); m_x = m_q;
          end else begin
            m_q = (m_cur[55:51] != 5'd7); m_x = (m_cur[55:51] != 5'd9);
          end
          m_rd  = (!is_spec(m_cur) && m_cur[46:45] == 2'b00) ? resp_data(m_cur) : 24'h0;
          m_noq = !m_q; m_nox = !m_x;
        end
        m_t++;
      end
    end
  end

  // feeder and downstream
  always @(negedge clk) begin
    while (npop < ntook) begin void'(fq.pop_front()); npop++; end
    cmd_valid = feed_en && (fq.size() > 0);
    cmd_frame = (fq.size() > 0) ? fq[0] : 64'h0;
    rsp_ready = !stall_mode || ((cyc % 11) < 4);
  end

  // per-clock comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit sp, wr, s1w, s2w, rv;
      sp  = is_spec(m_cur);
      wr  = !sp && (m_cur[46:45] == 2'b10);
      s1w = m_act && !sp && m_t >= TS && m_t < TS + T1;
      s2w = m_act && m_t >= TS + T1 && m_t < TS + T1 + T2 && (sp || !m_cur[40]);
      rv  = m_act && (m_t >= flen(m_cur));
      chk("R2/R9", "busy", 64'(bus_busy), 64'(m_act));
      chk("R1", "naf", 64'({bus_n, bus_a, bus_f}), m_act ? 64'(m_cur[55:42]) : 64'h0);
      chk("R1", "wdata", 64'(bus_wdata), (m_act && wr) ? 64'(m_cur[23:0]) : 64'h0);
      chk("R2", "s1", 64'(bus_s1), 64'(s1w));
      chk("R3", "s2", 64'(bus_s2), 64'(s2w));
      chk("R6", "c", 64'(bus_c), 64'(s2w && sp && m_cur[50:47] == 4'd0));
      chk("R6", "z", 64'(bus_z), 64'(s2w && sp && m_cur[50:47] == 4'd1));
      chk("R8", "rsp_valid", 64'(rsp_valid), 64'(rv));
      if (rv) chk("R4/R5", "rsp_frame", rsp_frame, {m_cur[63:42], m_q, m_x, m_cur[39:24], m_rd});
      chk("R7", "flags", 64'({noq_flag, nox_flag}), 64'({m_noq, m_nox}));
      chk("R10", "cmd_ready", 64'(cmd_ready), 64'(online && (!m_act || (rv && rsp_ready))));
      chk("R11", "pkt_done", 64'(pkt_done), 64'(m_pkt));
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (fq.size() > 0 || m_act);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk("R12", "reset busy/strobes", 64'({bus_busy, bus_s1, bus_s2, bus_c, bus_z}), 64'h0);
    chk("R12", "reset rsp/pkt/flags", 64'({rsp_valid, pkt_done, noq_flag, nox_flag}), 64'h0);
    chk("R12", "reset lines", 64'({bus_n, bus_a, bus_f}), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // single normal read
    fq.push_back(mk(1, 0, 3, 2, 0, 1, 0));
    wait_idle();
    // burst with back-pressure: write, fast read, no-Q, no-X, C, Z, bad special, control
    stall_mode = 1;
    fq.push_back(mk(0, 0, 4, 1, 16, 2, 24'hABCDEF));
    fq.push_back(mk(0, 1, 5, 3, 2, 3, 0));
    fq.push_back(mk(0, 0, 7, 0, 0, 4, 0));
    fq.push_back(mk(0, 1, 9, 4, 1, 5, 0));
    fq.push_back(mk(0, 1, STN, 0, 16, 6, 24'h123456));
    fq.push_back(mk(0, 0, STN, 1, 0, 7, 0));
    fq.push_back(mk(0, 0, STN, 5, 0, 8, 0));
    fq.push_back(mk(1, 1, 12, 6, 24, 9, 24'h777777));
    wait_idle();
    stall_mode = 0;
    // back-to-back with no stall, then offline mid-frame
    fq.push_back(mk(0, 0, 2, 7, 18, 10, 24'h0F0F0F));
    fq.push_back(mk(0, 1, 1, 8, 6, 11, 0));
    fq.push_back(mk(1, 0, 6, 9, 0, 12, 0));
    repeat (30) @(negedge clk);
    online = 1'b0;
    repeat (700) @(negedge clk);
    online = 1'b1;
    wait_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule